// File: doc/BRIEF.md
# Periodic Interrupt Generator With Flag

This block drives an active-low interrupt line from a 3-bit mode field. Four of the eight modes are simple or free-running: the line released, the line forced low, a 2 Hz square wave, and a 1 Hz square wave. The square waves come from an internal sub-second phase counter that advances on prescaler ticks. The other four modes are sticky level interrupts. A calendar event sets a flag, the flag pulls the line low, and the line stays low until software writes 0 to the flag. The event is a seconds increment, the seconds wrapping to 00, the minutes and seconds wrapping to 00, or the start of a new month.

The phase counter also produces a one-cycle carry strobe. The strobe comes a fixed number of ticks after the falling edge of the square wave, and the seconds counter of the calendar uses it to advance. A write to the seconds counter restarts the phase, so the square wave falls again. A stop or power-loss indication forces the mode back to the released state. The line is meant to be combined with the alarm outputs through an external wired-OR.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the mode is 000: `irq_n_o` is 1, `flag_o` is 0 and `sec_tick_o` is 0. Mode 000 keeps the line released.
- R2: Mode 001 drives `irq_n_o` to 0. In modes 000 and 001, `flag_o` reads 0.
- R3: Mode 011 (1 Hz) drives the line low while the phase counter is in the first half of the second (phase values 0 to TICKS_PER_SEC/2-1) and high for the rest of the second. In modes 010 and 011, `flag_o` reads 1 exactly when `irq_n_o` is 0.
- R4: Mode 010 (2 Hz) drives the line low in the first quarter of each half-second (phase values modulo TICKS_PER_SEC/2 below TICKS_PER_SEC/4) and high otherwise.
- R5: A pulse on `sec_wr_i` resets the phase to 0. In a square-wave mode, `irq_n_o` is then 0 two cycles after the pulse.
- R6: `sec_tick_o` is a one-cycle strobe. It appears the cycle after the CARRY_DLY-th tick that follows the phase reaching 0. Other ticks do not produce it.
- R7: Each level mode selects one event: 100 selects `sec_inc_i`, 101 selects `min_evt_i`, 110 selects `hour_evt_i` and 111 selects `month_evt_i`. The strobes that are not selected have no effect on the flag.
- R8: In a level mode, the selected event sets `flag_o` in the next cycle. `irq_n_o` goes low one cycle later and stays low until a write of 0 to the flag clears it.
- R9: A flag write of 1 has no effect. If an event and a write of 0 arrive in the same cycle, the event wins and the flag stays set.
- R10: `stop_i` sets the mode to 000 in the next cycle and clears the flag. It takes priority over a mode write in the same cycle. The line is then released, and later events are ignored.
- R11: `irq_n_o` is registered. It changes one cycle after the state that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick, advances the sub-second phase |
| sec_wr_i | input | 1 | Seconds counter written; restarts the phase |
| sec_inc_i | input | 1 | Seconds increment strobe |
| min_evt_i | input | 1 | Seconds wrapped to 00 |
| hour_evt_i | input | 1 | Minutes and seconds wrapped to 00 |
| month_evt_i | input | 1 | 00:00:00 on day one of a month |
| stop_i | input | 1 | Stop or power-loss: clears the mode |
| mode_we_i | input | 1 | Mode write enable |
| mode_wdata_i | input | 3 | Mode write data |
| flag_we_i | input | 1 | Flag write enable |
| flag_wdata_i | input | 1 | Flag write data (only 0 acts) |
| irq_n_o | output | 1 | Interrupt line, 0 = asserted |
| flag_o | output | 1 | Readable interrupt flag |
| sec_tick_o | output | 1 | Carry strobe to the seconds counter |

## Verification
The assertions check the following on every cycle:
- forced and released modes produce the expected line level;
- in level modes the line tracks the flag with one cycle of delay;
- a set flag holds until a clear, a mode write or a stop;
- the flag never rises without an event;
- the carry strobe lasts one cycle;
- a stop leaves the block in mode 000 with the flag clear.

Only the bench scenarios can show the following:
- the exact square-wave phase boundaries for 1 Hz and 2 Hz;
- the restart caused by a seconds write;
- which strobe each level mode selects;
- the tick on which the carry strobe lands.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [2:0] {
    PM_OFF   = 3'b000,
    PM_LOW   = 3'b001,
    PM_SQ2   = 3'b010,
    PM_SQ1   = 3'b011,
    PM_SEC   = 3'b100,
    PM_MIN   = 3'b101,
    PM_HOUR  = 3'b110,
    PM_MONTH = 3'b111
  } pirq_mode_e;

  function automatic logic is_level(pirq_mode_e m);
    return m[2];
  endfunction
endpackage

// File: rtl/pirq_phase.sv
module pirq_phase #(
  parameter int TICKS_PER_SEC = 16,
  parameter int CARRY_DLY     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic sq1_o,
  output logic sq2_o,
  output logic carry_o
);
  localparam int CW      = $clog2(TICKS_PER_SEC);
  localparam int HALF    = TICKS_PER_SEC / 2;
  localparam int QUARTER = TICKS_PER_SEC / 4;

  logic [CW-1:0] sub_q;
  logic          carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (restart_i)
        sub_q <= '0;
      else if (tick_i)
        sub_q <= (sub_q == CW'(TICKS_PER_SEC - 1)) ? '0 : sub_q + 1'b1;
      // carry lands CARRY_DLY ticks after the phase reaches zero
      carry_q <= tick_i && !restart_i && (sub_q == CW'(CARRY_DLY - 1));
    end
  end

  assign sq1_o = (sub_q < CW'(HALF));
  assign sq2_o = (sub_q < CW'(QUARTER)) ||
                 ((sub_q >= CW'(HALF)) && (sub_q < CW'(HALF + QUARTER)));
  assign carry_o = carry_q;
endmodule

// File: rtl/pirq_flag.sv
module pirq_flag
  import pirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pirq_mode_e mode_i,
  input  logic       stop_i,
  input  logic       sec_inc_i,
  input  logic       min_evt_i,
  input  logic       hour_evt_i,
  input  logic       month_evt_i,
  input  logic       flag_we_i,
  input  logic       flag_wdata_i,
  output logic       flag_o
);
  logic evt;
  logic flag_q;

  always_comb begin
    unique case (mode_i)
      PM_SEC:   evt = sec_inc_i;
      PM_MIN:   evt = min_evt_i;
      PM_HOUR:  evt = hour_evt_i;
      PM_MONTH: evt = month_evt_i;
      default:  evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      flag_q <= 1'b0;
    else if (stop_i || !is_level(mode_i))
      flag_q <= 1'b0;
    else if (evt)
      flag_q <= 1'b1;            // event beats a same-cycle clear
    else if (flag_we_i && !flag_wdata_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pirq_drive.sv
module pirq_drive
  import pirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pirq_mode_e mode_i,
  input  logic       sq1_i,
  input  logic       sq2_i,
  input  logic       flag_i,
  output logic       irq_n_o
);
  logic active;
  logic irq_n_q;

  always_comb begin
    unique case (mode_i)
      PM_OFF:  active = 1'b0;
      PM_LOW:  active = 1'b1;
      PM_SQ2:  active = sq2_i;
      PM_SQ1:  active = sq1_i;
      default: active = flag_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_n_q <= 1'b1;
    else         irq_n_q <= !active;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 16,
  parameter int CARRY_DLY     = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sec_wr_i,
  input  logic       sec_inc_i,
  input  logic       min_evt_i,
  input  logic       hour_evt_i,
  input  logic       month_evt_i,
  input  logic       stop_i,
  input  logic       mode_we_i,
  input  logic [2:0] mode_wdata_i,
  input  logic       flag_we_i,
  input  logic       flag_wdata_i,
  output logic       irq_n_o,
  output logic       flag_o,
  output logic       sec_tick_o
);
  pirq_mode_e mode_q;
  logic       sq1, sq2, lvl_flag, irq_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= PM_OFF;
    else if (stop_i)    mode_q <= PM_OFF;
    else if (mode_we_i) mode_q <= pirq_mode_e'(mode_wdata_i);
  end

  pirq_phase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CARRY_DLY    (CARRY_DLY)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(sec_wr_i),
    .sq1_o    (sq1),
    .sq2_o    (sq2),
    .carry_o  (sec_tick_o)
  );

  pirq_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .stop_i      (stop_i),
    .sec_inc_i   (sec_inc_i),
    .min_evt_i   (min_evt_i),
    .hour_evt_i  (hour_evt_i),
    .month_evt_i (month_evt_i),
    .flag_we_i   (flag_we_i),
    .flag_wdata_i(flag_wdata_i),
    .flag_o      (lvl_flag)
  );

  pirq_drive u_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .sq1_i  (sq1),
    .sq2_i  (sq2),
    .flag_i (lvl_flag),
    .irq_n_o(irq_n)
  );

  assign irq_n_o = irq_n;

  always_comb begin
    if (is_level(mode_q))                    flag_o = lvl_flag;
    else if (mode_q == PM_SQ1 || mode_q == PM_SQ2) flag_o = !irq_n;
    else                                     flag_o = 1'b0;
  end
endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sec_wr_i,
  input logic       sec_inc_i,
  input logic       min_evt_i,
  input logic       hour_evt_i,
  input logic       month_evt_i,
  input logic       stop_i,
  input logic       mode_we_i,
  input logic       flag_we_i,
  input logic       flag_wdata_i,
  input logic       irq_n_o,
  input logic       flag_o,
  input logic       sec_tick_o,
  input logic [2:0] mode_q
);
  logic any_evt;
  assign any_evt = sec_inc_i || min_evt_i || hour_evt_i || month_evt_i;

  // R1
  off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'b000) |=> irq_n_o);

  // R2
  forced_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'b001) |=> !irq_n_o);

  // R5
  restart_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_wr_i && mode_q == 3'b011 && !mode_we_i && !stop_i) |=> ##1 !irq_n_o);

  // R6
  carry_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[2] && flag_o && !stop_i && !mode_we_i && !(flag_we_i && !flag_wdata_i))
      |=> flag_o);

  // R9
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[2] && !flag_o && !any_evt && !mode_we_i && !stop_i) |=> !flag_o);

  // R11
  level_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[2] |=> (irq_n_o == !$past(flag_o)));

  // R10
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (mode_q == 3'b000 && !flag_o));
endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_wr_i    (sec_wr_i),
  .sec_inc_i   (sec_inc_i),
  .min_evt_i   (min_evt_i),
  .hour_evt_i  (hour_evt_i),
  .month_evt_i (month_evt_i),
  .stop_i      (stop_i),
  .mode_we_i   (mode_we_i),
  .flag_we_i   (flag_we_i),
  .flag_wdata_i(flag_wdata_i),
  .irq_n_o     (irq_n_o),
  .flag_o      (flag_o),
  .sec_tick_o  (sec_tick_o),
  .mode_q      (mode_q)
);

// File: tb/periodic_irq_gen_tb_top.sv
module periodic_irq_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, sec_wr_i = 0, sec_inc_i = 0, min_evt_i = 0;
  logic hour_evt_i = 0, month_evt_i = 0, stop_i = 0;
  logic mode_we_i = 0, flag_we_i = 0, flag_wdata_i = 0;
  logic [2:0] mode_wdata_i = '0;
  logic irq_n_o, flag_o, sec_tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  periodic_irq_gen #(.TICKS_PER_SEC(16), .CARRY_DLY(1)) dut_i (
    .clk_i, .rst_ni, .tick_i, .sec_wr_i, .sec_inc_i, .min_evt_i,
    .hour_evt_i, .month_evt_i, .stop_i, .mode_we_i, .mode_wdata_i,
    .flag_we_i, .flag_wdata_i, .irq_n_o, .flag_o, .sec_tick_o
  );

  // mode, ticks to apply, expected irq_n, expected flag (16 ticks per second)
  typedef struct packed {
    logic [2:0] mode;
    logic [4:0] ticks;
    logic       exp_irq_n;
    logic       exp_flag;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd3, 5'd0, 1'b0, 1'b1},  // phase 0
    '{3'd3, 5'd7, 1'b0, 1'b1},  // phase 7
    '{3'd3, 5'd1, 1'b1, 1'b0},  // phase 8
    '{3'd3, 5'd7, 1'b1, 1'b0},  // phase 15
    '{3'd3, 5'd1, 1'b0, 1'b1},  // phase 0 (wrap)
    '{3'd2, 5'd3, 1'b0, 1'b1},  // phase 3
    '{3'd2, 5'd1, 1'b1, 1'b0},  // phase 4
    '{3'd2, 5'd4, 1'b0, 1'b1},  // phase 8
    '{3'd2, 5'd4, 1'b1, 1'b0},  // phase 12
    '{3'd1, 5'd2, 1'b0, 1'b0},  // phase 14
    '{3'd0, 5'd1, 1'b1, 1'b0},  // phase 15
    '{3'd3, 5'd0, 1'b1, 1'b0}   // phase 15
  };

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr_mode(logic [2:0] m);
    mode_we_i = 1; mode_wdata_i = m;
    step();
    mode_we_i = 0;
  endtask

  task automatic wr_flag(logic v);
    flag_we_i = 1; flag_wdata_i = v;
    step();
    flag_we_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #23 rst_ni = 1'b1;
    step();
    check("R1", "irq_n after reset", irq_n_o, 1'b1);
    check("R1", "flag after reset", flag_o, 1'b0);
    check("R1", "carry after reset", sec_tick_o, 1'b0);

    sec_wr_i = 1; step(); sec_wr_i = 0;
    foreach (VECS[i]) begin
      string tag;
      case (VECS[i].mode)
        3'd3: tag = "R3";
        3'd2: tag = "R4";
        3'd1: tag = "R2";
        default: tag = "R1";
      endcase
      wr_mode(VECS[i].mode);
      for (int k = 0; k < int'(VECS[i].ticks); k++) begin
        tick_i = 1; step();
      end
      tick_i = 0;
      step(); step();
      check(tag, $sformatf("row %0d irq_n", i), irq_n_o, VECS[i].exp_irq_n);
      check(tag, $sformatf("row %0d flag", i), flag_o, VECS[i].exp_flag);
    end

    // R5: seconds write restarts phase (phase 15, line high)
    sec_wr_i = 1; step(); sec_wr_i = 0;
    step();
    check("R5", "irq_n after seconds write", irq_n_o, 1'b0);

    // R6: carry one tick after phase 0
    tick_i = 1; step(); tick_i = 0;
    check("R6", "carry strobe", sec_tick_o, 1'b1);
    step();
    check("R6", "carry one cycle", sec_tick_o, 1'b0);
    tick_i = 1; step(); step(); step(); tick_i = 0;
    check("R6", "no carry mid second", sec_tick_o, 1'b0);

    // R7/R8/R9/R11: seconds level mode
    wr_mode(3'b100);
    min_evt_i = 1; step(); min_evt_i = 0;
    check("R7", "unselected strobe in 100", flag_o, 1'b0);
    sec_inc_i = 1; step(); sec_inc_i = 0;
    check("R8", "flag set by seconds", flag_o, 1'b1);
    check("R11", "irq_n lags flag", irq_n_o, 1'b1);
    step();
    check("R8", "irq_n low on flag", irq_n_o, 1'b0);
    wr_flag(1'b1); step();
    check("R9", "write 1 keeps flag", flag_o, 1'b1);
    check("R9", "write 1 keeps irq", irq_n_o, 1'b0);
    wr_flag(1'b0);
    check("R8", "flag cleared", flag_o, 1'b0);
    step();
    check("R8", "irq_n released", irq_n_o, 1'b1);

    // minute mode
    wr_mode(3'b101);
    sec_inc_i = 1; step(); sec_inc_i = 0;
    check("R7", "seconds ignored in 101", flag_o, 1'b0);
    min_evt_i = 1; step(); min_evt_i = 0;
    check("R7", "minute sets flag", flag_o, 1'b1);
    min_evt_i = 1; flag_we_i = 1; flag_wdata_i = 0; step();
    min_evt_i = 0; flag_we_i = 0;
    check("R9", "event beats clear", flag_o, 1'b1);
    wr_flag(1'b0);

    // hour mode
    wr_mode(3'b110);
    min_evt_i = 1; step(); min_evt_i = 0;
    check("R7", "minute ignored in 110", flag_o, 1'b0);
    hour_evt_i = 1; step(); hour_evt_i = 0;
    check("R7", "hour sets flag", flag_o, 1'b1);
    wr_flag(1'b0);

    // month mode
    wr_mode(3'b111);
    hour_evt_i = 1; step(); hour_evt_i = 0;
    check("R7", "hour ignored in 111", flag_o, 1'b0);
    month_evt_i = 1; step(); month_evt_i = 0;
    check("R7", "month sets flag", flag_o, 1'b1);
    step();
    check("R8", "irq_n low in month mode", irq_n_o, 1'b0);

    // R10: stop beats mode write
    stop_i = 1; mode_we_i = 1; mode_wdata_i = 3'b011; step();
    stop_i = 0; mode_we_i = 0;
    check("R10", "flag cleared by stop", flag_o, 1'b0);
    step();
    check("R10", "irq_n released by stop", irq_n_o, 1'b1);
    month_evt_i = 1; step(); month_evt_i = 0;
    step();
    check("R10", "event ignored after stop", flag_o, 1'b0);
    check("R10", "line stays released", irq_n_o, 1'b1);

    finish_run();
  end
endmodule